// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block decides when an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) takes an exception, and which one it takes. Each of the first four stages can raise its own kind of fault, and an external interrupt can arrive at any time. A fault raised in fetch, decode or execute is not acted on immediately. It is recorded against its instruction and travels down the pipe with it. The memory stage is the commit point, and that is where the controller looks for an exception to take. An instruction can only reach that point after every older instruction has gone past it, so the exception taken always belongs to the oldest faulting instruction. Older instructions always retire normally.

When an exception is taken, the controller acts in the following cycle. It writes the exception program counter (EPC) and the cause code, raises a flush for the faulting instruction and every younger one, and steers fetch to a fixed handler address. The records of any younger faulting instructions are discarded. The EPC and cause values stay on their output pins until the next exception, so the pipeline can read them back.

Top module: `precise_exc_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `redirect_o` is 0, `flush_o` is 0, and `epc_o` and `cause_o` are 0.
- R2: The cause codes written to `cause_o` are:
  - 0 for an external interrupt.
  - 4 for a fetch page fault.
  - 5 for a data page fault.
  - 10 for an undefined instruction.
  - 12 for an arithmetic overflow.
- R3: An exception is detected in any cycle in which the memory stage holds a valid instruction that carries a fault. In the next cycle, `redirect_o` is high for exactly one cycle, and `epc_o` and `cause_o` show the new values. In all other cycles `epc_o` and `cause_o` hold their previous values.
- R4: When several instructions fault in the same cycle, the exception taken is the one from the instruction furthest down the pipe.
- R5: When one instruction raises faults in more than one stage, it keeps the fault from the earliest stage. That fault is the one reported.
- R6: Taking an exception discards the faults already recorded for younger instructions. Those faults never cause a later redirect.
- R7: `flush_o` has one bit per stage: bit 0 is fetch and bit 4 is writeback. In the redirect cycle, bits 0 to 3 are all 1. Bit 4 is 1 only if the pipeline advanced (`adv_i` high) in the detection cycle.
- R8: For an overflow, `epc_o` is the memory-stage address plus 4. For every other cause, it is the memory-stage address itself.
- R9: An interrupt is attached to the instruction in the memory stage. It is taken only when that stage is valid, and only if that instruction carries no fault of its own.
- R10: In the redirect cycle, `redirect_pc_o` carries the handler address parameter.
- R11: Fault requests from fetch, decode and execute are recorded only when the pipeline advances and the requesting stage is valid. A request raised on an invalid stage has no effect.
- R12: In the cycle of a redirect, the controller ignores memory-stage faults and interrupts, so two redirects never come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | All stages advance at this clock edge |
| vld_i | input | 4 | Valid instruction in each stage: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory |
| if_pgflt_i | input | 1 | Fetch page fault |
| id_undef_i | input | 1 | Undefined instruction in decode |
| ex_ovf_i | input | 1 | Arithmetic overflow in execute |
| mem_pgflt_i | input | 1 | Data page fault in memory stage |
| irq_i | input | 1 | External interrupt request |
| pc_mem_i | input | XLEN | Address of the memory-stage instruction |
| redirect_o | output | 1 | Fetch is steered to the handler this cycle |
| redirect_pc_o | output | XLEN | Handler address |
| flush_o | output | 5 | Per-stage flush: bit 0 fetch through bit 4 writeback |
| epc_o | output | XLEN | Exception program counter register |
| cause_o | output | 5 | Cause register |

## Verification
Two cases are the interesting ones.

The first is a new detection landing in the same cycle as the flush and redirect of the previous one. The bench provokes it by raising a data page fault and an interrupt against a valid memory-stage instruction during the redirect cycle. It then expects no second redirect and unchanged EPC and cause values.

The second is several stages faulting in one cycle. The bench raises a fetch fault together with an execute overflow, and an interrupt together with a data page fault. It judges each case by the cause and EPC that come out, and by the absence of any later redirect from the discarded younger fault.

Long constrained-random runs with stalls and fetch bubbles are compared cycle by cycle against a pipeline model kept in the bench.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

  // Stage count of the pipe and the number of stages whose faults are carried
  localparam int NSTG = 5;
  localparam int NTRK = 3;
  localparam int CAUSE_W = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CS_IRQ      = 5'd0,
    CS_PF_FETCH = 5'd4,
    CS_PF_DATA  = 5'd5,
    CS_UNDEF    = 5'd10,
    CS_OVF      = 5'd12
  } cause_e;

  // A fault attached to one instruction
  typedef struct packed {
    logic   vld;
    cause_e cause;
  } xrec_t;

  localparam xrec_t REC_NONE = '{vld: 1'b0, cause: CS_IRQ};

endpackage

// File: rtl/pexc_track.sv
// Carries fault records alongside instructions from fetch down to the
// memory stage. Slot k belongs to the instruction in stage k+1.
module pexc_track
  import pexc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              kill,
  input  logic [NTRK-1:0]   src_vld,
  input  xrec_t [NTRK-1:0]  raise,
  output xrec_t             mem_rec
);

  genvar k;
  generate
    for (k = 0; k < NTRK; k++) begin : g_slot
      xrec_t q;
      xrec_t feed;

      if (k == 0) begin : g_head
        assign feed = raise[0];
      end else begin : g_body
        // the earliest fault of an instruction wins over a later one
        assign feed = g_slot[k-1].q.vld ? g_slot[k-1].q : raise[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= REC_NONE;
        end else if (kill) begin
          q <= REC_NONE;
        end else if (adv) begin
          q <= src_vld[k] ? feed : REC_NONE;
        end
      end
    end
  endgenerate

  assign mem_rec = g_slot[NTRK-1].q;

endmodule

// File: rtl/pexc_arb.sv
// Commit-point selection: memory-stage instruction fault first, then its
// own data page fault, then an interrupt attached to it.
module pexc_arb
  import pexc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            mem_vld,
  input  logic            block,
  input  xrec_t           mem_rec,
  input  logic            mem_pf,
  input  logic            irq,
  input  logic [XLEN-1:0] pc_mem,
  output logic            take,
  output cause_e          cause,
  output logic [XLEN-1:0] epc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    take  = 1'b0;
    cause = CS_IRQ;
    if (mem_vld && !block) begin
      if (mem_rec.vld) begin
        take  = 1'b1;
        cause = mem_rec.cause;
      end else if (mem_pf) begin
        take  = 1'b1;
        cause = CS_PF_DATA;
      end else if (irq) begin
        take  = 1'b1;
        cause = CS_IRQ;
      end
    end
  end

  // an overflow resumes after the faulting instruction
  assign epc = (cause == CS_OVF) ? pc_mem + STEP : pc_mem;

endmodule

// File: rtl/pexc_commit.sv
// Registers the taken exception: EPC, cause, redirect and per-stage flush.
module pexc_commit
  import pexc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               adv,
  input  cause_e             cause,
  input  logic [XLEN-1:0]    epc,
  output logic               take_q,
  output logic [NSTG-1:0]    flush,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q
);

  logic adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      adv_q   <= 1'b0;
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      take_q <= take;
      adv_q  <= adv;
      if (take) begin
        epc_q   <= epc;
        cause_q <= cause;
      end
    end
  end

  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_fl
      if (s == NSTG - 1) begin : g_wb
        // faulting instruction sits in writeback only if the pipe moved
        assign flush[s] = take_q & adv_q;
      end else begin : g_front
        assign flush[s] = take_q;
      end
    end
  endgenerate

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
  import pexc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic [3:0]         vld_i,
  input  logic               if_pgflt_i,
  input  logic               id_undef_i,
  input  logic               ex_ovf_i,
  input  logic               mem_pgflt_i,
  input  logic               irq_i,
  input  logic [XLEN-1:0]    pc_mem_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [NSTG-1:0]    flush_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);

  xrec_t [NTRK-1:0] raise;
  xrec_t            mem_rec;
  logic             take;
  logic             take_q;
  cause_e           sel_cause;
  logic [XLEN-1:0]  sel_epc;

  always_comb begin
    raise[0] = '{vld: vld_i[0] & if_pgflt_i, cause: CS_PF_FETCH};
    raise[1] = '{vld: vld_i[1] & id_undef_i, cause: CS_UNDEF};
    raise[2] = '{vld: vld_i[2] & ex_ovf_i,   cause: CS_OVF};
  end

  pexc_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv_i),
    .kill    (take | take_q),
    .src_vld (vld_i[NTRK-1:0]),
    .raise   (raise),
    .mem_rec (mem_rec)
  );

  pexc_arb #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_arb (
    .mem_vld (vld_i[3]),
    .block   (take_q),
    .mem_rec (mem_rec),
    .mem_pf  (mem_pgflt_i),
    .irq     (irq_i),
    .pc_mem  (pc_mem_i),
    .take    (take),
    .cause   (sel_cause),
    .epc     (sel_epc)
  );

  pexc_commit #(.XLEN(XLEN)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .adv     (adv_i),
    .cause   (sel_cause),
    .epc     (sel_epc),
    .take_q  (take_q),
    .flush   (flush_o),
    .epc_q   (epc_o),
    .cause_q (cause_o)
  );

  assign redirect_o    = take_q;
  assign redirect_pc_o = HANDLER_PC;

endmodule

// File: rtl/precise_exc_ctrl_chk.sv
module precise_exc_ctrl_chk
  import pexc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adv_i,
  input logic [3:0]         vld_i,
  input logic               if_pgflt_i,
  input logic               id_undef_i,
  input logic               ex_ovf_i,
  input logic               mem_pgflt_i,
  input logic               irq_i,
  input logic [XLEN-1:0]    pc_mem_i,
  input logic               redirect_o,
  input logic [XLEN-1:0]    redirect_pc_o,
  input logic [NSTG-1:0]    flush_o,
  input logic [XLEN-1:0]    epc_o,
  input logic [CAUSE_W-1:0] cause_o
);

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (cause_o == 5'd0 || cause_o == 5'd4 || cause_o == 5'd5 ||
                    cause_o == 5'd10 || cause_o == 5'd12)); // R2

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> ($stable(epc_o) && $stable(cause_o))); // R3

  AST_DETECT_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect_o) |-> $past(vld_i[3])); // R3

  AST_FRONT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (flush_o[3:0] == 4'hF)); // R7

  AST_WB_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (flush_o[4] == $past(adv_i))); // R7

  AST_QUIET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> (flush_o == '0)); // R7

  AST_OVF_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && cause_o == 5'd12) |-> (epc_o == $past(pc_mem_i) + XLEN'(INSN_BYTES))); // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && cause_o == 5'd0) |-> $past(irq_i && vld_i[3])); // R9

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o); // R12

endmodule

bind precise_exc_ctrl precise_exc_ctrl_chk #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_chk (.*);

// File: tb/precise_exc_ctrl_bench.sv
`timescale 1ns/1ps
module precise_exc_ctrl_bench;

  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i;
  logic [3:0]  vld_i;
  logic        if_pgflt_i, id_undef_i, ex_ovf_i, mem_pgflt_i, irq_i;
  logic [31:0] pc_mem_i;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic [4:0]  flush_o;
  logic [31:0] epc_o;
  logic [4:0]  cause_o;

  always #2.5 clk = ~clk;

  precise_exc_ctrl u_precise_exc_ctrl (.*);

  int checks = 0;
  int fails  = 0;
  int n_redir = 0;
  bit done = 1'b0;

  // bench pipeline model: stages 0..3 = fetch..memory
  bit          m_v  [4];
  logic [31:0] m_pc [4];
  bit          m_tv [4];
  logic [4:0]  m_tc [4];
  bit          fl;
  bit          bub;
  logic [31:0] x_epc;
  logic [4:0]  x_cause;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] code_of(input int s);
    case (s)
      0: return 5'd4;
      1: return 5'd10;
      default: return 5'd12;
    endcase
  endfunction

  // one cycle: drive at negedge, predict, check after the edge, advance model
  task automatic drive_cycle(input bit a, input bit f0, input bit f1, input bit f2,
                             input bit f3, input bit iq);
    bit tk;
    bit r [3];
    logic [4:0] c;
    r[0] = f0; r[1] = f1; r[2] = f2;
    adv_i = a; if_pgflt_i = f0; id_undef_i = f1; ex_ovf_i = f2;
    mem_pgflt_i = f3; irq_i = iq;
    vld_i = {m_v[3], m_v[2], m_v[1], m_v[0]};
    pc_mem_i = m_pc[3];
    tk = !fl && m_v[3] && (m_tv[3] || f3 || iq);
    c  = m_tv[3] ? m_tc[3] : (f3 ? 5'd5 : 5'd0);
    if (tk) begin
      x_epc   = m_pc[3] + ((c == 5'd12) ? 32'd4 : 32'd0);
      x_cause = c;
    end
    @(posedge clk);
    @(negedge clk);
    chk(redirect_o == tk, "R3 redirect", 32'(redirect_o), 32'(tk));
    chk(flush_o == (tk ? {a, 4'hF} : 5'h0), "R7 flush", 32'(flush_o), 32'(tk ? {a, 4'hF} : 5'h0));
    chk(epc_o == x_epc, "R8 epc", epc_o, x_epc);
    chk(cause_o == x_cause, "R2 cause", 32'(cause_o), 32'(x_cause));
    if (redirect_o) n_redir++;
    if (fl) begin
      for (int s = 0; s < 4; s++) begin
        m_v[s] = 1'b0; m_tv[s] = 1'b0;
      end
      m_v[0] = 1'b1; m_pc[0] = HANDLER;
    end else if (a) begin
      for (int s = 3; s >= 1; s--) begin
        m_tv[s] = m_v[s-1] && (m_tv[s-1] || r[s-1]);
        m_tc[s] = m_tv[s-1] ? m_tc[s-1] : code_of(s-1);
        m_v[s]  = m_v[s-1];
        m_pc[s] = m_pc[s-1];
      end
      m_v[0] = !bub; m_pc[0] = m_pc[0] + 32'd4; m_tv[0] = 1'b0;
    end
    fl = tk;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) drive_cycle(1'b1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcx;
    int nr;
    int seed_val;
    rst_n = 1'b0; adv_i = 0; vld_i = '0; if_pgflt_i = 0; id_undef_i = 0;
    ex_ovf_i = 0; mem_pgflt_i = 0; irq_i = 0; pc_mem_i = '0;
    for (int s = 0; s < 4; s++) begin
      m_v[s] = 0; m_pc[s] = '0; m_tv[s] = 0; m_tc[s] = '0;
    end
    m_v[0] = 1'b1; m_pc[0] = 32'h1000;
    fl = 0; bub = 0; x_epc = '0; x_cause = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(redirect_o == 1'b0 && flush_o == 5'h0, "R1 reset outputs", {27'd0, flush_o}, 32'd0);
    chk(epc_o == 32'd0 && cause_o == 5'd0, "R1 reset regs", epc_o, 32'd0);
    rst_n = 1'b1;

    // R4 R6: fetch fault and execute overflow together
    quiet(4);
    pcx = m_pc[2];
    drive_cycle(1, 1, 0, 1, 0, 0);
    drive_cycle(1, 0, 0, 0, 0, 0);
    chk(cause_o == 5'd12, "R4 oldest wins", 32'(cause_o), 32'd12);
    chk(epc_o == pcx + 32'd4, "R8 overflow epc", epc_o, pcx + 32'd4);
    chk(redirect_pc_o == HANDLER, "R10 handler", redirect_pc_o, HANDLER);
    chk(flush_o == 5'h1F, "R7 flush with advance", 32'(flush_o), 32'h1F);
    nr = n_redir;
    drive_cycle(1, 0, 0, 0, 0, 0);
    quiet(5);
    chk(n_redir == nr, "R6 younger discarded", 32'(n_redir - nr), 32'd0);

    // R9: interrupt with data page fault; R12 during redirect cycle
    quiet(4);
    pcx = m_pc[3];
    drive_cycle(1, 0, 0, 0, 1, 1);
    chk(cause_o == 5'd5, "R9 fault over interrupt", 32'(cause_o), 32'd5);
    chk(epc_o == pcx, "R8 data fault epc", epc_o, pcx);
    drive_cycle(1, 0, 0, 0, 1, 1);
    chk(redirect_o == 1'b0, "R12 ignored in redirect cycle", 32'(redirect_o), 32'd0);
    chk(epc_o == pcx, "R12 epc held", epc_o, pcx);

    // R7 R9: interrupt alone while stalled
    quiet(4);
    pcx = m_pc[3];
    drive_cycle(0, 0, 0, 0, 0, 1);
    chk(cause_o == 5'd0 && epc_o == pcx, "R9 interrupt", epc_o, pcx);
    chk(flush_o == 5'h0F, "R7 flush while stalled", 32'(flush_o), 32'h0F);
    drive_cycle(1, 0, 0, 0, 0, 0);

    // R11: requests on invalid stages
    nr = n_redir;
    drive_cycle(0, 0, 1, 1, 1, 1);
    drive_cycle(1, 0, 1, 1, 1, 1);
    quiet(4);
    chk(n_redir == nr, "R11 invalid stage requests", 32'(n_redir - nr), 32'd0);

    // R5: same instruction faults in fetch then execute
    quiet(4);
    pcx = m_pc[0];
    drive_cycle(1, 1, 0, 0, 0, 0);
    drive_cycle(1, 0, 0, 0, 0, 0);
    drive_cycle(1, 0, 0, 1, 0, 0);
    drive_cycle(1, 0, 0, 0, 0, 0);
    chk(cause_o == 5'd4 && epc_o == pcx, "R5 earliest fault kept", {27'd0, cause_o}, 32'd4);
    drive_cycle(1, 0, 0, 0, 0, 0);

    // constrained random against the model
    seed_val = $urandom(32'd1234);
    for (int i = 0; i < 4000; i++) begin
      bub = ($urandom % 5) == 0;
      drive_cycle(($urandom % 4) != 0, ($urandom % 20) == 0, ($urandom % 20) == 0,
                  ($urandom % 20) == 0, ($urandom % 25) == 0, ($urandom % 30) == 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule